// File: doc/BRIEF.md
# Oversampled Debug Serial Slave Port

This block is the slave end of a three-wire debug link. It has a serial clock input, a serial data input and a serial data output. An external master drives the serial clock and sets the bit rate. Inside the port every register runs on the system clock. The serial clock is not used as a clock: the port passes it through a two-stage synchronizer and watches for a low-to-high transition, and each transition it finds advances the port by one bit. A packet is 17 bits long: one control/status bit comes first, then a 16-bit word, and the most significant bit leads. The link is full duplex, so one bit goes out for every bit that comes in.

On the core side the port presents each received packet as a control bit and a 16-bit word, along with a one-cycle valid strobe. The core hands in the answer for the next packet by pulsing a response strobe with a status bit and a 16-bit word. That answer is held until the current packet ends, and then it is moved into the transmit shifter. If the core gave no answer, the next packet carries status 1, which means not ready, and a zero word.

Top module: `dbg_serial_port`

## Requirements
- R1: While reset is asserted and right after it, `sdo_o` is 1 and `rx_valid_o` is 0.
- R2: Once 17 qualified serial clock rises have been seen, `rx_valid_o` is high for exactly one cycle. `rx_ctrl_o` holds the first bit received and `rx_data_o` holds the next 16 bits, with the earliest of them in bit 15. Both outputs keep their values until the next packet completes.
- R3: Take the system clock rising edge that first samples the serial clock high as edge 1. The port samples `sdi_i` through the same two-stage delay. The packet-complete strobe appears after edge 3, and `sdo_o` changes to its next value after edge 4. Before edge 4, `sdo_o` does not change.
- R4: A serial clock that stays high for any number of cycles counts as one bit. A new bit is counted only after the serial clock has been sampled low at least once.
- R5: `sdo_o` shows bit 16 of the transmit word (the status bit) before the first rise of a packet. After the k-th rise it shows bit 16-k. After the 17th rise it shows the status bit of the next transmit word.
- R6: If no response is pending when a packet completes, the next transmit word is status 1 with data 0x0000. This is also the word after reset.
- R7: A response strobe (`rsp_valid_i`) loads {`rsp_status_i`, `rsp_data_i`} as the pending response, replacing any earlier pending one. A pending response is used once.
- R8: While the serial clock is low, changes on `sdi_i` have no effect on the received packet.
- R9: The port runs correctly with a serial clock at one fifth of the system clock, and at any slower rate. A new packet can begin right after the previous one, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Serial clock from the master, asynchronous |
| sdi_i | input | 1 | Serial data from the master, asynchronous |
| sdo_o | output | 1 | Serial data to the master |
| rx_valid_o | output | 1 | One-cycle strobe when a packet completes |
| rx_ctrl_o | output | 1 | Control bit of the last packet |
| rx_data_o | output | 16 | Data word of the last packet |
| rsp_valid_i | input | 1 | Load the response for the next packet |
| rsp_status_i | input | 1 | Status bit of the response |
| rsp_data_i | input | 16 | Data word of the response |

## Verification
If the bit counter is off, the completion strobe moves to the wrong rise. That shows up within a single packet as a misframed `rx_data_o`, and `sdo_o` drifts out of phase with the master. If the edge qualifier or the synchronizer depth is wrong, `sdo_o` moves one or more cycles away from the fourth edge, and the per-cycle output check catches it on the first bit. If the pending-response logic is wrong, the next packet shows the wrong status bit on `sdo_o` before its first rise.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
   // Number of bits in one packet: a leading control/status bit plus the word
   function automatic int pkt_bits(input int data_w);
      return data_w + 1;
   endfunction

   // Width of a counter that indexes every bit position of a packet
   function automatic int cnt_bits(input int data_w);
      return $clog2(data_w + 1);
   endfunction
endpackage

// File: rtl/dsp_sync.sv
module dsp_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dsp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else if (s == 0) chain[s] <= d_i;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dsp_edge.sv
module dsp_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o
);
   logic lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/dsp_shift.sv
module dsp_shift
   import dsp_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              bit_i,
   output logic              sdo_o,
   output logic              rx_valid_o,
   output logic              rx_ctrl_o,
   output logic [DATA_W-1:0] rx_data_o,
   input  logic              rsp_valid_i,
   input  logic              rsp_status_i,
   input  logic [DATA_W-1:0] rsp_data_i
);
   localparam int PKT_W = pkt_bits(DATA_W);
   localparam int CNT_W = cnt_bits(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_W - 1);
   localparam logic [PKT_W-1:0] IDLE_WORD = {1'b1, {DATA_W{1'b0}}};

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("dsp_shift: DATA_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [PKT_W-1:0] rx_sr_q;
   logic [PKT_W-1:0] tx_sr_q;
   logic [PKT_W-1:0] pend_word_q;
   logic             pend_q;
   logic             sdo_q;
   logic             valid_q;
   logic             ctrl_q;
   logic [DATA_W-1:0] data_q;
   logic             done;
   logic [PKT_W-1:0] load_word;
   logic [PKT_W-1:0] rx_full;

   assign done    = step_i && (cnt_q == LAST);
   assign rx_full = {rx_sr_q[PKT_W-2:0], bit_i};

   always_comb begin
      if (rsp_valid_i)  load_word = {rsp_status_i, rsp_data_i};
      else if (pend_q)  load_word = pend_word_q;
      else              load_word = IDLE_WORD;
   end

   // bit position and receive shifter
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         rx_sr_q <= '0;
         valid_q <= 1'b0;
         ctrl_q  <= 1'b0;
         data_q  <= '0;
      end else begin
         valid_q <= done;
         if (step_i) begin
            rx_sr_q <= rx_full;
            if (done) begin
               cnt_q  <= '0;
               ctrl_q <= rx_full[PKT_W-1];
               data_q <= rx_full[DATA_W-1:0];
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // pending response holding register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_word_q <= IDLE_WORD;
      end else if (done) begin
         pend_q <= 1'b0;
      end else if (rsp_valid_i) begin
         pend_q      <= 1'b1;
         pend_word_q <= {rsp_status_i, rsp_data_i};
      end
   end

   // transmit shifter and registered output bit
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_sr_q <= IDLE_WORD;
         sdo_q   <= 1'b1;
      end else begin
         sdo_q <= tx_sr_q[PKT_W-1];
         if (done)        tx_sr_q <= load_word;
         else if (step_i) tx_sr_q <= {tx_sr_q[PKT_W-2:0], 1'b0};
      end
   end

   assign sdo_o      = sdo_q;
   assign rx_valid_o = valid_q;
   assign rx_ctrl_o  = ctrl_q;
   assign rx_data_o  = data_q;

   // R2: completion strobe lasts one cycle
   a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);

   // R2: the bit position never leaves the packet
   a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R2: after completion the position restarts at zero
   a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |-> (cnt_q == '0));

   // R3: the output bit moves only two edges after a qualified rise
   a_r3_sdo_timing: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdo_o) |-> $past(step_i, 2));

   // R6: an empty response slot yields the not-ready word
   a_r6_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rsp_valid_i && !pend_q) |=> (tx_sr_q == IDLE_WORD));
endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
   import dsp_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sdi_i,
   output logic              sdo_o,
   output logic              rx_valid_o,
   output logic              rx_ctrl_o,
   output logic [DATA_W-1:0] rx_data_o,
   input  logic              rsp_valid_i,
   input  logic              rsp_status_i,
   input  logic [DATA_W-1:0] rsp_data_i
);
   logic [1:0] raw_in;
   logic [1:0] sync_out;
   logic       step;

   assign raw_in = {sclk_i, sdi_i};

   dsp_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (sync_out)
   );

   dsp_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (sync_out[1]),
      .rise_o (step)
   );

   dsp_shift #(.DATA_W(DATA_W)) u_shift (
      .clk          (clk),
      .rst_n        (rst_n),
      .step_i       (step),
      .bit_i        (sync_out[0]),
      .sdo_o        (sdo_o),
      .rx_valid_o   (rx_valid_o),
      .rx_ctrl_o    (rx_ctrl_o),
      .rx_data_o    (rx_data_o),
      .rsp_valid_i  (rsp_valid_i),
      .rsp_status_i (rsp_status_i),
      .rsp_data_i   (rsp_data_i)
   );
endmodule

// File: tb/sim_dbg_serial_port.sv
`timescale 1ns/1ps
module sim_dbg_serial_port;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        sclk, sdi, sdo;
   logic        rx_valid, rx_ctrl;
   logic [15:0] rx_data;
   logic        rsp_valid, rsp_status;
   logic [15:0] rsp_data;

   int checks = 0;
   int fails  = 0;
   logic [16:0] tx_word;
   logic [16:0] pend_word;
   logic        pend;
   int unsigned seed_v;

   always #2.5 clk = ~clk;

   dbg_serial_port u0 (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo),
      .rx_valid_o(rx_valid), .rx_ctrl_o(rx_ctrl), .rx_data_o(rx_data),
      .rsp_valid_i(rsp_valid), .rsp_status_i(rsp_status), .rsp_data_i(rsp_data)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [16:0] next_word();
      return pend ? pend_word : 17'h10000;
   endfunction

   task automatic give_rsp(input logic st, input logic [15:0] d);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_status = st; rsp_data = d;
      @(negedge clk);
      rsp_valid = 1'b0;
      pend = 1'b1; pend_word = {st, d};
   endtask

   // one packet; high h cycles, low l cycles per bit; h+l >= 5
   task automatic send_packet(input logic [16:0] w, input int h, input int l);
      logic [16:0] nxt;
      logic exp_cur, exp_nxt;
      nxt = next_word();
      for (int i = 0; i < 17; i++) begin
         exp_cur = tx_word[16-i];
         exp_nxt = (i < 16) ? tx_word[15-i] : nxt[16];
         chk(sdo === exp_cur, "R5 sdo before rise", {31'b0, sdo}, {31'b0, exp_cur});
         sdi = w[16-i];
         sclk = 1'b1;
         for (int c = 1; c <= h + l; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c == h) sclk = 1'b0;
            if (c >= h) sdi = 1'($urandom(seed_v) & 1);   // R8 noise while low
            if (c < 4)
               chk(sdo === exp_cur, "R3 sdo held before edge 4", {31'b0, sdo}, {31'b0, exp_cur});
            else if (c == 4)
               chk(sdo === exp_nxt, "R3 sdo after edge 4", {31'b0, sdo}, {31'b0, exp_nxt});
            if (i == 16) begin
               chk(rx_valid === (c == 3), "R2 rx_valid pulse", {31'b0, rx_valid}, {31'b0, c == 3});
               if (c == 3)
                  chk({rx_ctrl, rx_data} === w, "R2 R8 received packet", {15'b0, rx_ctrl, rx_data}, {15'b0, w});
            end else begin
               chk(rx_valid === 1'b0, "R4 no early strobe", {31'b0, rx_valid}, 32'd0);
            end
         end
      end
      tx_word = nxt;
      pend = 1'b0;
      chk({rx_ctrl, rx_data} === w, "R2 received packet held", {15'b0, rx_ctrl, rx_data}, {15'b0, w});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      seed_v = 32'd12345;
      rst_n = 1'b0; sclk = 1'b0; sdi = 1'b0;
      rsp_valid = 1'b0; rsp_status = 1'b0; rsp_data = '0;
      pend = 1'b0; pend_word = '0; tx_word = 17'h10000;
      repeat (4) @(negedge clk);
      chk(sdo === 1'b1 && rx_valid === 1'b0, "R1 during reset", {30'b0, sdo, rx_valid}, 32'h2);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(sdo === 1'b1 && rx_valid === 1'b0, "R1 after reset", {30'b0, sdo, rx_valid}, 32'h2);

      // R4 long high period, R6 idle word after reset
      send_packet(17'h1A5A5, 9, 3);
      // R9 max rate with a response
      give_rsp(1'b0, 16'hC3A5);
      send_packet(17'h0F00F, 2, 3);
      // R6 no response pending -> not-ready word
      send_packet(17'h15555, 1, 4);
      // R7 newer response replaces older one
      give_rsp(1'b0, 16'h1234);
      give_rsp(1'b1, 16'hBEEF);
      send_packet(17'h0AAAA, 3, 2);
      send_packet(17'h00001, 4, 4);
      // R9 back-to-back at max rate, random
      for (int p = 0; p < 40; p++) begin
         int h, l;
         h = 1 + int'($urandom(seed_v) % 6);
         l = 1 + int'($urandom(seed_v) % 6);
         if (h + l < 5) l = 5 - h;
         if (($urandom(seed_v) % 3) != 0)
            give_rsp(1'($urandom(seed_v) & 1), 16'($urandom(seed_v)));
         send_packet(17'($urandom(seed_v)), h, l);
      end
      for (int p = 0; p < 3; p++) send_packet(17'h1FFFF - 17'(p), 2, 3);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule